// File: doc/BRIEF.md
# Low-Byte Exchange Bridge for a 24-bit Program Bus

This block sits between a 24-bit program-memory data path and a core whose data registers are 16 bits wide. A hidden 8-bit side register carries the byte that does not fit. A 24-bit memory read sends the top sixteen bits to the destination register and parks the bottom byte in the side register. A 24-bit memory write takes its top sixteen bits from a source register and its bottom byte from the side register. As a result, 16-bit registers can move complete 24-bit words. A read followed at once by a write of the same register copies a full word, and no extra instruction is needed to carry the low byte.

The core can also load the side register directly from the low byte of a 16-bit value. It can read the side register back, zero-extended, as a 16-bit value. A small behavioural memory is built in so the data movement can be checked. Its address space is split into a 24-bit region and a 16-bit region. Reads from the 16-bit region clear the side register. Writes to that region store only the sixteen source bits. Decoding of instructions and generation of addresses belong to other blocks.

Top module: `lowbyte_exchange`

## Requirements
- R1: A read (`mem_rd_i`) from the 24-bit region places word bits [23:8] on `dst_o` and bits [7:0] in the side register, both after the same clock edge.
- R2: A write (`mem_wr_i`) to the 24-bit region stores the word {`src_i`, side register} (source in bits [23:8]), using the side register value from before that edge.
- R3: A read from the 16-bit region places the stored 16-bit word on `dst_o` and loads 0x00 into the side register.
- R4: A direct load (`xreg_ld_i`) keeps only `src_i[7:0]` in the side register.
- R5: A side-register read (`xreg_rd_i`) places {8'h00, side register} on `dst_o` after the next edge.
- R6: A write to the 16-bit region stores `src_i` alone and leaves the side register unchanged.
- R7: When a memory read coincides with a direct load, the side register takes the memory byte. When it coincides with a side-register read, `dst_o` takes the memory data.
- R8: A 24-bit read, then a 24-bit write of the value just read on `dst_o` to another address, reproduces the full 24-bit word at the new address.
- R9: Reset clears `dst_o` and the side register to zero.
- R10: `addr_i[15]` = 0 selects the 24-bit region and = 1 selects the 16-bit region. Within a region, the word index is the low address bits modulo that region's depth (256 words by default).
- R11: The side register holds its value in any cycle without a memory read or a direct load, including cycles with memory writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd_i | input | 1 | Read memory at `addr_i` into the destination register |
| mem_wr_i | input | 1 | Write memory at `addr_i` from `src_i` and the side register |
| xreg_ld_i | input | 1 | Load side register from `src_i[7:0]` |
| xreg_rd_i | input | 1 | Move zero-extended side register to the destination register |
| addr_i | input | 16 | Memory word address; bit 15 selects the region |
| src_i | input | 16 | Source register value |
| dst_o | output | 16 | Destination register |

## Verification
The assertions check the following on every cycle: the side register follows the memory's low byte on a wide read and clears on a narrow read; a lone direct load keeps exactly the source's low byte; the register holds when neither a read nor a load occurs; and a side-register read gives a zero upper byte. Other behaviours need a sequence of operations, so only the bench scenarios can show them. These include that stored words really combine the source and the old side-register byte, that narrow writes leave the register alone, that address aliasing works, and that a read-then-write copies all 24 bits. The bench also shows the result of colliding requests.

// File: rtl/lbx_pkg.sv
package lbx_pkg;
  localparam int WIDE_W   = 24;
  localparam int NARROW_W = 16;
  localparam int BYTE_W   = WIDE_W - NARROW_W;

  typedef struct packed {
    logic [NARROW_W-1:0] hi;
    logic [BYTE_W-1:0]   lo;
  } wide_split_t;

  // Break a wide memory word into register part and leftover byte.
  function automatic wide_split_t split_word(input logic [WIDE_W-1:0] w);
    wide_split_t s;
    s.hi = w[WIDE_W-1:BYTE_W];
    s.lo = w[BYTE_W-1:0];
    return s;
  endfunction

  // Rebuild a wide word from a register value and the side byte.
  function automatic logic [WIDE_W-1:0] join_word(input logic [NARROW_W-1:0] hi,
                                                  input logic [BYTE_W-1:0]   lo);
    return {hi, lo};
  endfunction

  // Side byte presented on the narrow bus.
  function automatic logic [NARROW_W-1:0] widen_byte(input logic [BYTE_W-1:0] b);
    return {{(NARROW_W-BYTE_W){1'b0}}, b};
  endfunction
endpackage

// File: rtl/lbx_region_mem.sv
module lbx_region_mem
  import lbx_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WIDE_AW   = 8,
  parameter int NARROW_AW = 8
) (
  input  logic                clk,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [NARROW_W-1:0] wr_hi,
  input  logic [BYTE_W-1:0]   wr_lo,
  output logic                is_wide,
  output logic [WIDE_W-1:0]   wide_rdata,
  output logic [NARROW_W-1:0] narrow_rdata
);
  localparam int WIDE_DEPTH   = 1 << WIDE_AW;
  localparam int NARROW_DEPTH = 1 << NARROW_AW;

  logic [WIDE_W-1:0]   wide_q   [WIDE_DEPTH];
  logic [NARROW_W-1:0] narrow_q [NARROW_DEPTH];

  logic [WIDE_AW-1:0]   widx;
  logic [NARROW_AW-1:0] nidx;
  logic                 unused_addr_bits;

  assign is_wide = ~addr[ADDR_W-1];
  assign widx    = addr[WIDE_AW-1:0];
  assign nidx    = addr[NARROW_AW-1:0];
  assign unused_addr_bits = ^addr;

  assign wide_rdata   = wide_q[widx];
  assign narrow_rdata = narrow_q[nidx];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (is_wide) wide_q[widx] <= join_word(wr_hi, wr_lo);
      else         narrow_q[nidx] <= wr_hi;
    end
  end
endmodule

// File: rtl/lbx_xreg.sv
module lbx_xreg
  import lbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [BYTE_W-1:0] fill_val,
  input  logic              ld_en,
  input  logic [BYTE_W-1:0] ld_val,
  output logic [BYTE_W-1:0] q
);
  // A memory fill wins over a direct load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (fill_en) q <= fill_val;
    else if (ld_en)   q <= ld_val;
  end

  AST_LOAD_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !fill_en) |=> q == $past(ld_val)); // R4

  AST_SIDE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !fill_en) |=> $stable(q)); // R11
endmodule

// File: rtl/lowbyte_exchange.sv
module lowbyte_exchange
  import lbx_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WIDE_AW   = 8,
  parameter int NARROW_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_rd_i,
  input  logic              mem_wr_i,
  input  logic              xreg_ld_i,
  input  logic              xreg_rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       src_i,
  output logic [15:0]       dst_o
);
  logic                is_wide;
  logic [WIDE_W-1:0]   wide_rdata;
  logic [NARROW_W-1:0] narrow_rdata;
  logic [BYTE_W-1:0]   side_q;
  wide_split_t         rd_split;
  logic [NARROW_W-1:0] rd_hi;
  logic [BYTE_W-1:0]   rd_lo;
  logic [NARROW_W-1:0] dst_q;

  lbx_region_mem #(
    .ADDR_W(ADDR_W), .WIDE_AW(WIDE_AW), .NARROW_AW(NARROW_AW)
  ) u_mem (
    .clk          (clk),
    .addr         (addr_i),
    .wr_en        (mem_wr_i),
    .wr_hi        (src_i),
    .wr_lo        (side_q),
    .is_wide      (is_wide),
    .wide_rdata   (wide_rdata),
    .narrow_rdata (narrow_rdata)
  );

  assign rd_split = split_word(wide_rdata);
  assign rd_hi    = is_wide ? rd_split.hi : narrow_rdata;
  assign rd_lo    = is_wide ? rd_split.lo : '0;

  lbx_xreg u_xreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill_en  (mem_rd_i),
    .fill_val (rd_lo),
    .ld_en    (xreg_ld_i),
    .ld_val   (src_i[BYTE_W-1:0]),
    .q        (side_q)
  );

  // Memory data wins over the side-register read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dst_q <= '0;
    else if (mem_rd_i)  dst_q <= rd_hi;
    else if (xreg_rd_i) dst_q <= widen_byte(side_q);
  end

  assign dst_o = dst_q;

  AST_WIDE_READ_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_i && is_wide) |=> side_q == $past(wide_rdata[7:0])); // R1

  AST_NARROW_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_i && !is_wide) |=> side_q == 8'h00); // R3

  AST_SIDE_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (xreg_rd_i && !mem_rd_i) |=> dst_o[15:8] == 8'h00); // R5

  AST_NARROW_READ_DST: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_i && !is_wide) |=> dst_o == $past(narrow_rdata)); // R3
endmodule

// File: tb/lowbyte_exchange_test.sv
`timescale 1ns/1ps
module lowbyte_exchange_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_rd_i = 1'b0, mem_wr_i = 1'b0, xreg_ld_i = 1'b0, xreg_rd_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [15:0] src_i = '0;
  logic [15:0] dst_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lowbyte_exchange uut (
    .clk(clk), .rst_n(rst_n), .mem_rd_i(mem_rd_i), .mem_wr_i(mem_wr_i),
    .xreg_ld_i(xreg_ld_i), .xreg_rd_i(xreg_rd_i), .addr_i(addr_i),
    .src_i(src_i), .dst_o(dst_o)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: dst_o=%h expected=%h", req, got, exp);
    end
  endtask

  // Apply one cycle of controls; returns after the edge, at the falling edge.
  task automatic step(input bit rd, input bit wr, input bit ld, input bit xr,
                      input logic [15:0] a, input logic [15:0] s);
    @(negedge clk);
    mem_rd_i = rd; mem_wr_i = wr; xreg_ld_i = ld; xreg_rd_i = xr;
    addr_i = a; src_i = s;
    @(negedge clk);
    mem_rd_i = 0; mem_wr_i = 0; xreg_ld_i = 0; xreg_rd_i = 0;
  endtask

  task automatic side_load(input logic [15:0] s); step(0, 0, 1, 0, 16'h0, s); endtask
  task automatic side_read();                     step(0, 0, 0, 1, 16'h0, 16'h0); endtask
  task automatic mem_write(input logic [15:0] a, input logic [15:0] s); step(0, 1, 0, 0, a, s); endtask
  task automatic mem_read(input logic [15:0] a);  step(1, 0, 0, 0, a, 16'h0); endtask

  task automatic t_reset();
    check("R9 dst after reset", dst_o, 16'h0000);
    side_read();
    check("R9 side after reset", dst_o, 16'h0000);
  endtask

  task automatic t_wide();
    side_load(16'h33A5);
    side_read();
    check("R4 low byte kept", dst_o, 16'h00A5);
    mem_write(16'h0010, 16'hBEEF);
    side_load(16'h0000);
    mem_read(16'h0010);
    check("R1 upper bits to dst", dst_o, 16'hBEEF);
    side_read();
    check("R2 R5 stored low byte", dst_o, 16'h00A5);
  endtask

  task automatic t_narrow();
    side_load(16'hFF77);
    mem_write(16'h8020, 16'hCAFE);
    side_read();
    check("R6 side untouched by narrow write", dst_o, 16'h0077);
    mem_read(16'h8020);
    check("R6 R10 narrow word stored", dst_o, 16'hCAFE);
    side_read();
    check("R3 narrow read zero fill", dst_o, 16'h0000);
  endtask

  task automatic t_priority();
    side_load(16'h0011);
    step(1, 0, 1, 1, 16'h0010, 16'h0099);
    check("R7 memory beats side read on dst", dst_o, 16'hBEEF);
    side_read();
    check("R7 memory beats direct load", dst_o, 16'h00A5);
  endtask

  task automatic t_copy();
    logic [15:0] held;
    side_load(16'h00C3);
    mem_write(16'h0030, 16'h1234);
    mem_read(16'h0030);
    held = dst_o;
    mem_write(16'h0040, held);
    side_load(16'h0000);
    mem_read(16'h0040);
    check("R8 copy upper", dst_o, 16'h1234);
    side_read();
    check("R8 copy low byte", dst_o, 16'h00C3);
  endtask

  task automatic t_region();
    mem_write(16'h8010, 16'h5555);
    mem_read(16'h0110);
    check("R10 wide alias modulo depth", dst_o, 16'hBEEF);
    mem_read(16'h8110);
    check("R10 narrow alias modulo depth", dst_o, 16'h5555);
  endtask

  task automatic t_hold();
    side_load(16'hA15C);
    mem_write(16'h0050, 16'h0001);
    mem_write(16'h8050, 16'h0002);
    step(0, 0, 0, 0, 16'h0, 16'hFFFF);
    side_read();
    check("R11 side holds", dst_o, 16'h005C);
    mem_read(16'h0050);
    side_read();
    check("R2 write used held byte", dst_o, 16'h005C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wide();
    t_narrow();
    t_priority();
    t_copy();
    t_region();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule